// File: doc/BRIEF.md
# Per-Pin Condition Detector with Port Interrupt

This block watches a port of general-purpose input pins and raises one interrupt request for the whole port when any pin meets the condition chosen for it. Each pin owns a configuration word that picks its pin function, stores two pad pull bits, and carries a 4-bit trigger code choosing low level, high level, rising edge, falling edge or either edge. Every pin is brought into the clock domain through a two-flop synchronizer, and edges are judged against the previous synchronized sample.

A shared status word holds one sticky flag per pin. Software reads it to find the source, and clears flags by writing ones. The port interrupt is the OR of all flags. A per-pin state machine has two states, DET_DISARMED and DET_ARMED. Transition ARM fires when the pin is in general-purpose function with a valid trigger code. Transition DISARM fires when either of those stops holding. Conditions are reported only while the pin is armed and its configuration is still valid.

Register access is a simple single-cycle bus. Word addresses 0 to NUM_PINS-1 hold the pin configuration words, and address NUM_PINS holds the status word. Reads are combinational and writes take effect at the clock edge.

Top module: `pin_event_port`

## Requirements
- R1: After reset every configuration word reads 0, the status word reads 0 and `port_irq` is low.
- R2: A configuration word keeps trigger code in bits [3:0], function select in bits [6:4], pull enable in bit 8 and pull select in bit 9; these read back exactly as written and all other bits read 0.
- R3: Only a pin whose function select equals 1 sets its flag; any other function value suppresses detection.
- R4: Trigger code 4'b1000 sets the pin's flag on every cycle its synchronized input is low.
- R5: Trigger code 4'b1100 sets the pin's flag on every cycle its synchronized input is high.
- R6: Trigger code 4'b1001 sets the flag when the synchronized input goes from 0 to 1.
- R7: Trigger code 4'b1010 sets the flag when the synchronized input goes from 1 to 0.
- R8: Trigger code 4'b1011 sets the flag on either transition.
- R9: Trigger code 0000 and all codes not listed in R4 to R8 never set a flag.
- R10: Writing the status address clears exactly the flags whose data bits are 1; data bits of 0 leave flags unchanged.
- R11: When a condition is detected in the same cycle that its flag is written with 1, the flag stays set.
- R12: `port_irq` is high exactly when at least one status flag is set.
- R13: A pin change presented before clock edge 0 is not visible in the status word after edge 1 and is visible after edge 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Word address: pin configuration words, then status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| port_irq | output | 1 | Combined port interrupt request |

## Verification
All sixteen trigger codes are placed on sixteen pins at once and driven through a low hold, a rise, a fall and a second low hold, clearing flags between phases. The rise phase tells rising and either-edge pins from falling ones, the fall phase does the reverse, and the low holds after a clear separate level modes, which re-set at once, from edge modes, which stay clear. A sweep of all eight function-select values under a rising edge isolates the general-purpose gate. Single-pin runs measure the two-edge synchronizer latency exactly and set a clear write against a persisting level to show that the set takes priority.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

    localparam int          WORD_W    = 32;
    localparam logic [2:0]  FUNC_GPIO = 3'd1;

    localparam logic [3:0]  TRG_OFF   = 4'b0000;
    localparam logic [3:0]  TRG_LOW   = 4'b1000;
    localparam logic [3:0]  TRG_RISE  = 4'b1001;
    localparam logic [3:0]  TRG_FALL  = 4'b1010;
    localparam logic [3:0]  TRG_BOTH  = 4'b1011;
    localparam logic [3:0]  TRG_HIGH  = 4'b1100;

    typedef enum logic {
        DET_DISARMED,
        DET_ARMED
    } det_state_e;

    typedef struct packed {
        logic       pull_sel;
        logic       pull_en;
        logic [2:0] func;
        logic [3:0] trig;
    } pin_cfg_t;

    function automatic logic trig_valid(logic [3:0] t);
        return (t == TRG_LOW) || (t == TRG_RISE) || (t == TRG_FALL) ||
               (t == TRG_BOTH) || (t == TRG_HIGH);
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(pin_cfg_t c);
        logic [WORD_W-1:0] w;
        w      = '0;
        w[3:0] = c.trig;
        w[6:4] = c.func;
        w[8]   = c.pull_en;
        w[9]   = c.pull_sel;
        return w;
    endfunction

    function automatic pin_cfg_t word_to_cfg(logic [9:0] w);
        pin_cfg_t c;
        c.trig     = w[3:0];
        c.func     = w[6:4];
        c.pull_en  = w[8];
        c.pull_sel = w[9];
        return c;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] raw_in,
    output logic [NUM_PINS-1:0] sync_out
);
    logic [NUM_PINS-1:0] stage1_q;
    logic [NUM_PINS-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs
    import pinirq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [9:0]             wfield,
    output logic [NUM_PINS-1:0][3:0] trig_o,
    output logic [NUM_PINS-1:0]    gpio_sel_o,
    output logic [WORD_W-1:0]      rd_word
);
    localparam logic [WORD_W-1:0] FIELD_MASK = 32'h0000_037F;

    pin_cfg_t cfg_q [NUM_PINS];

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_q[i] <= '0;
            else if (wr && addr == ADDR_W'(i))
                cfg_q[i] <= word_to_cfg(wfield);
        end

        assign trig_o[i]     = cfg_q[i].trig;
        assign gpio_sel_o[i] = (cfg_q[i].func == FUNC_GPIO);

        // R2: a write lands in its word with only the defined fields kept
        p_cfg_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr && addr == ADDR_W'(i)) |->
                cfg_to_word(cfg_q[i]) == ({22'd0, $past(wfield)} & FIELD_MASK));
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (addr == ADDR_W'(i))
                rd_word = cfg_to_word(cfg_q[i]);
        end
    end
endmodule

// File: rtl/pin_detector.sv
module pin_detector
    import pinirq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PINS-1:0]      sync_in,
    input  logic [NUM_PINS-1:0][3:0] trig,
    input  logic [NUM_PINS-1:0]      gpio_sel,
    output logic [NUM_PINS-1:0]      hit
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_det
        det_state_e state_q;
        det_state_e state_d;
        logic       prev_q;
        logic       cfg_ok;

        assign cfg_ok = gpio_sel[i] && trig_valid(trig[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q <= DET_DISARMED;
                prev_q  <= 1'b0;
            end else begin
                state_q <= state_d;
                prev_q  <= sync_in[i];
            end
        end

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                DET_DISARMED: if (cfg_ok)  state_d = DET_ARMED;     // ARM
                DET_ARMED:    if (!cfg_ok) state_d = DET_DISARMED;  // DISARM
                default:      state_d = DET_DISARMED;
            endcase
        end

        always_comb begin
            hit[i] = 1'b0;
            if (state_q == DET_ARMED && cfg_ok) begin
                unique case (trig[i])
                    TRG_LOW:  hit[i] = !sync_in[i];
                    TRG_HIGH: hit[i] = sync_in[i];
                    TRG_RISE: hit[i] = sync_in[i] && !prev_q;
                    TRG_FALL: hit[i] = !sync_in[i] && prev_q;
                    TRG_BOTH: hit[i] = sync_in[i] != prev_q;
                    default:  hit[i] = 1'b0;
                endcase
            end
        end

        // R3: a pin outside general-purpose function never reports
        p_func_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !gpio_sel[i] |-> !hit[i]);
    end
endmodule

// File: rtl/pin_status.sv
module pin_status #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] hit,
    input  logic                clr_wr,
    input  logic [NUM_PINS-1:0] clr_bits,
    output logic [NUM_PINS-1:0] flags
);
    logic [NUM_PINS-1:0] clr_mask;

    assign clr_mask = clr_wr ? clr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~clr_mask) | hit;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R11: a detection in the clear cycle leaves the flag set
        p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            $past(hit[i]) |-> flags[i]);
        // R10: a one written with no detection clears the flag
        p_clear_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(clr_mask[i]) && !$past(hit[i])) |-> !flags[i]);
        // R10: no flag rises without a detection
        p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(hit[i]) && !$past(flags[i])) |-> !flags[i]);
    end
endmodule

// File: rtl/pin_event_port.sv
module pin_event_port
    import pinirq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic                port_irq
);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_PINS);

    logic [NUM_PINS-1:0]      sync_s;
    logic [NUM_PINS-1:0][3:0] trig_s;
    logic [NUM_PINS-1:0]      gpio_s;
    logic [NUM_PINS-1:0]      hit_s;
    logic [NUM_PINS-1:0]      flags_s;
    logic [WORD_W-1:0]        cfg_rd_s;

    pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_out(sync_s)
    );

    pin_cfg_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wfield(bus_wdata[9:0]), .trig_o(trig_s), .gpio_sel_o(gpio_s),
        .rd_word(cfg_rd_s)
    );

    pin_detector #(.NUM_PINS(NUM_PINS)) u_det (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_s), .trig(trig_s),
        .gpio_sel(gpio_s), .hit(hit_s)
    );

    pin_status #(.NUM_PINS(NUM_PINS)) u_stat (
        .clk(clk), .rst_n(rst_n), .hit(hit_s),
        .clr_wr(bus_wr && bus_addr == STATUS_ADDR),
        .clr_bits(bus_wdata[NUM_PINS-1:0]), .flags(flags_s)
    );

    always_comb begin
        if (bus_addr == STATUS_ADDR)
            bus_rdata = WORD_W'(flags_s);
        else
            bus_rdata = cfg_rd_s;
    end

    assign port_irq = |flags_s;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_edge_chk
        // R6: a rising report needs a 0 to 1 step at the synchronizer
        p_rise_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_s[i] == TRG_RISE && hit_s[i]) |-> (sync_s[i] && !$past(sync_s[i])));
        // R7: a falling report needs a 1 to 0 step
        p_fall_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_s[i] == TRG_FALL && hit_s[i]) |-> (!sync_s[i] && $past(sync_s[i])));
        // R9: codes outside the defined set stay silent
        p_reserved_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !trig_valid(trig_s[i]) |-> !hit_s[i]);
    end
endmodule

// File: tb/pin_event_port_bench.sv
`timescale 1ns/1ps
module pin_event_port_bench;
    localparam int NP = 32;
    localparam int AW = 6;
    localparam logic [AW-1:0] ST = AW'(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic          port_irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pin_event_port #(.NUM_PINS(NP), .ADDR_W(AW)) u_pin_event_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .port_irq(port_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // expected flag for a trigger code in each sweep phase
    function automatic logic exp_flag(input int code, input int phase);
        logic l = (code == 8), r = (code == 9), f = (code == 10);
        logic b = (code == 11), h = (code == 12);
        case (phase)
            0: return l;
            1: return l | r | b | h;
            2: return l | f | b | h;
            default: return l;
        endcase
    endfunction

    function automatic logic [31:0] sweep_mask(input int phase);
        logic [31:0] m = '0;
        for (int c = 0; c < 16; c++) m[c + 8] = exp_flag(c, phase);
        return m;
    endfunction

    initial begin
        logic [31:0] d;
        logic [31:0] sw;
        int bad;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        bad = 0;
        for (int a = 0; a <= NP; a++) begin
            rd(AW'(a), d);
            if (d !== 32'd0) bad++;
        end
        chk("R1 all words zero", 32'(bad), 32'd0);
        chk("R1 irq low", {31'd0, port_irq}, 32'd0);

        // R2: readback of defined fields
        wr(AW'(5), 32'hFFFF_FFFF);
        rd(AW'(5), d);
        chk("R2 all ones masked", d, 32'h0000_037F);
        wr(AW'(5), 32'hA5A5_0255);
        rd(AW'(5), d);
        chk("R2 pattern", d, 32'h0000_0255);
        wr(AW'(5), 32'h0);

        // R4 R5 R6 R7 R8 R9: all 16 codes on pins 8..23, function 1
        for (int c = 0; c < 16; c++) wr(AW'(c + 8), 32'h10 | 32'(c));
        tick(4);
        wr(ST, 32'hFFFF_FFFF);
        tick(4);
        sw = 32'h00FF_FF00;
        for (int ph = 0; ph < 4; ph++) begin
            if (ph == 1) pin_in[23:8] = '1;
            if (ph == 2) pin_in[23:8] = '0;
            tick(6);
            rd(ST, d);
            for (int c = 0; c < 16; c++) begin
                string tg;
                tg = $sformatf("R4/R5/R6/R7/R8/R9 code %0d phase %0d", c, ph);
                chk(tg, {31'd0, d[c + 8]}, {31'd0, sweep_mask(ph)[c + 8]});
            end
            chk("R12 irq follows flags", {31'd0, port_irq}, {31'd0, |(d & sw)});
            wr(ST, 32'hFFFF_FFFF);
        end

        // R3: function select sweep on pins 0..7 with rising trigger
        for (int f = 0; f < 8; f++) wr(AW'(f), 32'(f << 4) | 32'h9);
        tick(3);
        wr(ST, 32'h0000_00FF);
        pin_in[7:0] = '1;
        tick(6);
        rd(ST, d);
        for (int f = 0; f < 8; f++)
            chk($sformatf("R3 func %0d", f), {31'd0, d[f]}, {31'd0, f == 1});

        // R10: write of zeros leaves flags, one-bit write clears just that bit
        wr(ST, 32'h0);
        rd(ST, d);
        chk("R10 zero write no effect", d & 32'hFF, 32'h02);
        wr(ST, 32'h0000_0002);
        rd(ST, d);
        chk("R10 ones clear bit", d & 32'hFF, 32'h00);

        // R11: low-level pin 16 still low; clear loses to the set
        wr(ST, 32'h0001_0000);
        rd(ST, d);
        chk("R11 set wins", {31'd0, d[16]}, 32'd1);

        // R12: quiet port drops irq
        for (int a = 0; a < 24; a++) wr(AW'(a), 32'h0);
        tick(3);
        wr(ST, 32'hFFFF_FFFF);
        tick(2);
        rd(ST, d);
        chk("R12 status empty", d, 32'h0);
        chk("R12 irq low", {31'd0, port_irq}, 32'd0);

        // R13: exact latency on pin 31, rising trigger
        wr(AW'(31), 32'h19);
        tick(3);
        pin_in[31] = 1'b1;
        tick(1);
        tick(1);
        rd(ST, d);
        chk("R13 not yet after edge 1", {31'd0, d[31]}, 32'd0);
        tick(1);
        rd(ST, d);
        chk("R13 set after edge 2", {31'd0, d[31]}, 32'd1);
        chk("R12 irq high", {31'd0, port_irq}, 32'd1);
        wr(ST, 32'h8000_0000);
        tick(4);
        rd(ST, d);
        chk("R6 held high stays clear", {31'd0, d[31]}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule